// File: doc/BRIEF.md
# Alternate-Lane Widening Vector Multiplier

This unit takes two 128-bit vector operands and multiplies only every other element of each, either the even-numbered or the odd-numbered elements. Each product is kept at twice the element width, so the eight byte products (or four halfword products) fill a whole 128-bit result.

Three control inputs set the operation. One picks even or odd lanes, one picks signed or unsigned arithmetic, and one picks byte or halfword elements. Running the even operation and then the odd operation on the same operands gives every element product. No saturation or status of any kind is produced.

The result is registered. A two-state controller tracks whether the output register holds a fresh result:

- `ST_IDLE`: no fresh result is held.
- `ST_HOLD`: a result captured on the previous clock is on the output.

The controller has these transitions:

- `IDLE->HOLD` and `HOLD->HOLD` happen when `in_valid` is high.
- `HOLD->IDLE` and `IDLE->IDLE` happen when it is low.
- Reset forces `ST_IDLE`.

Top module: `vwm_top`

## Requirements
- R1: With `sel_odd`=0, `is_signed`=1 and `half_mode`=0, result halfword i (bits 127-16i down to 112-16i) equals the product of byte lane 2i of `op_a` and byte lane 2i of `op_b`, for i = 0..7. Byte lane k occupies bits 127-8k down to 120-8k, so lane 0 is the most significant byte.
- R2: With `sel_odd`=1, byte lanes 2i+1 are used instead of 2i. The result placement is the same as in R1.
- R3: With `is_signed`=1, each element is sign-extended before it is multiplied. The product is the full two's-complement value with no saturation, so 0x80 times 0x80 gives 0x4000 and 0x80 times 0x7F gives 0xC080.
- R4: With `is_signed`=0, each element is zero-extended before it is multiplied, so 0xFF times 0xFF gives 0xFE01.
- R5: With `half_mode`=1, halfword lane k (bits 127-16k down to 112-16k) is used, taking lane 2i or lane 2i+1 according to `sel_odd`. Result word i lands in bits 127-32i down to 96-32i. In signed mode 0x8000 times 0x8000 gives 0x40000000.
- R6: `out_valid` is high exactly one clock after a cycle with `in_valid` high. The matching result is on `result` in that same cycle.
- R7: After a cycle with `in_valid` low, `out_valid` is low and `result` keeps its previous value.
- R8: While the synchronous active-high `rst` is asserted, both `out_valid` and `result` are cleared to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 128 | First vector operand |
| op_b | input | 128 | Second vector operand |
| sel_odd | input | 1 | 1 selects odd lanes, 0 selects even lanes |
| is_signed | input | 1 | 1 selects signed elements, 0 selects unsigned elements |
| half_mode | input | 1 | 1 selects halfword elements, 0 selects byte elements |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 128 | Widened products, big-endian lane order |

## Verification
Every result and valid flag is due on the first rising edge after the inputs are presented. The bench drives inputs on the falling edge. On that same edge it updates a behavioural model to the value the design will hold after the next rising edge. On the following falling edge it compares `out_valid` and `result` with that model, which keeps every comparison exactly one register stage behind its stimulus. Cycles with `in_valid` low check that the held value is unchanged. Reset cycles check the cleared state one edge later.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } vwm_state_e;

    typedef enum logic [0:0] {
        ELEM_BYTE = 1'b0,
        ELEM_HALF = 1'b1
    } vwm_elem_e;
endpackage

// File: rtl/vwm_lane_pick.sv
module vwm_lane_pick #(
    parameter int VEC_W = 128,
    parameter int EW    = 8
) (
    input  logic [VEC_W-1:0]   vec,
    input  logic               odd,
    output logic [VEC_W/2-1:0] picked
);
    localparam int PAIRS = VEC_W / (2 * EW);

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        localparam int HI_EVEN = VEC_W - 1 - (2 * i) * EW;
        localparam int HI_ODD  = HI_EVEN - EW;
        localparam int HI_OUT  = VEC_W / 2 - 1 - i * EW;
        always_comb begin
            picked[HI_OUT -: EW] = odd ? vec[HI_ODD -: EW] : vec[HI_EVEN -: EW];
        end
    end
endmodule

// File: rtl/vwm_lane_mul.sv
module vwm_lane_mul #(
    parameter int EW = 8
) (
    input  logic [EW-1:0]   a,
    input  logic [EW-1:0]   b,
    input  logic            sgn,
    output logic [2*EW-1:0] p
);
    localparam int XW = EW + 1;

    logic signed [XW-1:0]     a_x;
    logic signed [XW-1:0]     b_x;
    logic signed [2*XW-1:0]   full;

    always_comb begin
        a_x  = {sgn & a[EW-1], a};
        b_x  = {sgn & b[EW-1], b};
        full = a_x * b_x;
        p    = full[2*EW-1:0];
    end

    always_comb begin
        if (sgn && (a == {1'b1, {(EW-1){1'b0}}}) && (b == {1'b1, {(EW-1){1'b0}}})) begin
            AST_MIN_SQUARE_POSITIVE: assert (p == {2'b01, {(2*EW-2){1'b0}}}); // R3
        end
        if (!sgn && (a == {EW{1'b1}}) && (b == {EW{1'b1}})) begin
            AST_UNSIGNED_MAX_SQUARE: assert (p == {{(EW-1){1'b1}}, 1'b0, {(EW-1){1'b0}}, 1'b1}); // R4
        end
    end
endmodule

// File: rtl/vwm_top.sv
module vwm_top #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    input  logic             sel_odd,
    input  logic             is_signed,
    input  logic             half_mode,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    import vwm_pkg::*;

    localparam int BW      = 8;
    localparam int HW      = 16;
    localparam int B_LANES = VEC_W / (2 * BW);
    localparam int H_LANES = VEC_W / (2 * HW);
    localparam int HALF_W  = VEC_W / 2;

    logic [HALF_W-1:0] a_b_pick, b_b_pick, a_h_pick, b_h_pick;
    logic [VEC_W-1:0]  byte_res, half_res, next_res;
    vwm_state_e        state_q, state_d;
    vwm_elem_e         elem_sel;

    vwm_lane_pick #(.VEC_W(VEC_W), .EW(BW)) u_pick_ab (.vec(op_a), .odd(sel_odd), .picked(a_b_pick));
    vwm_lane_pick #(.VEC_W(VEC_W), .EW(BW)) u_pick_bb (.vec(op_b), .odd(sel_odd), .picked(b_b_pick));
    vwm_lane_pick #(.VEC_W(VEC_W), .EW(HW)) u_pick_ah (.vec(op_a), .odd(sel_odd), .picked(a_h_pick));
    vwm_lane_pick #(.VEC_W(VEC_W), .EW(HW)) u_pick_bh (.vec(op_b), .odd(sel_odd), .picked(b_h_pick));

    for (genvar i = 0; i < B_LANES; i++) begin : g_bmul
        vwm_lane_mul #(.EW(BW)) u_mul (
            .a   (a_b_pick[HALF_W-1-i*BW -: BW]),
            .b   (b_b_pick[HALF_W-1-i*BW -: BW]),
            .sgn (is_signed),
            .p   (byte_res[VEC_W-1-i*2*BW -: 2*BW])
        );
    end

    for (genvar i = 0; i < H_LANES; i++) begin : g_hmul
        vwm_lane_mul #(.EW(HW)) u_mul (
            .a   (a_h_pick[HALF_W-1-i*HW -: HW]),
            .b   (b_h_pick[HALF_W-1-i*HW -: HW]),
            .sgn (is_signed),
            .p   (half_res[VEC_W-1-i*2*HW -: 2*HW])
        );
    end

    always_comb begin
        elem_sel = half_mode ? ELEM_HALF : ELEM_BYTE;
        unique case (elem_sel)
            ELEM_BYTE: next_res = byte_res;
            ELEM_HALF: next_res = half_res;
            default:   next_res = byte_res;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           result <= '0;
        else if (in_valid) result <= next_res;
    end

    assign out_valid = (state_q == ST_HOLD);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R6
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && result == '0)); // R8
endmodule

// File: tb/vwm_top_tb.sv
module vwm_top_tb;
    logic         clk = 1'b0;
    logic         rst, in_valid, sel_odd, is_signed, half_mode;
    logic [127:0] op_a, op_b;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    logic         m_valid;
    logic [127:0] m_res;
    string        m_tag;
    bit           done = 0;

    always #10 clk = ~clk;

    vwm_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sel_odd(sel_odd), .is_signed(is_signed), .half_mode(half_mode),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [127:0] ref_mul(logic [127:0] a, logic [127:0] b,
                                             bit odd, bit sgn, bit half);
        logic [127:0] r = '0;
        int ew = half ? 16 : 8;
        int n  = half ? 4 : 8;
        for (int i = 0; i < n; i++) begin
            int k = 2 * i + (odd ? 1 : 0);
            longint av = 0, bv = 0, pr;
            logic [63:0] p64;
            for (int j = 0; j < ew; j++) begin
                av[j] = a[127 - k * ew - (ew - 1) + j];
                bv[j] = b[127 - k * ew - (ew - 1) + j];
            end
            if (sgn && av[ew-1]) av = av - (longint'(1) << ew);
            if (sgn && bv[ew-1]) bv = bv - (longint'(1) << ew);
            pr  = av * bv;
            p64 = pr;
            for (int j = 0; j < 2 * ew; j++) r[127 - i * 2 * ew - (2 * ew - 1) + j] = p64[j];
        end
        return r;
    endfunction

    function automatic string tag_of(bit odd, bit sgn, bit half);
        if (half) return "R5";
        if (!sgn) return "R4";
        if (odd)  return "R2";
        return "R1";
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== m_valid) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b", m_valid ? "R6" : "R7", out_valid, m_valid);
        end
        checks++;
        if (result !== m_res) begin
            errors++;
            $display("FAIL %s result actual %h expected %h", m_tag, result, m_res);
        end
    endtask

    task automatic step(bit r, bit v, logic [127:0] a, logic [127:0] b, bit odd, bit sgn, bit half);
        @(negedge clk);
        if (!done) check_out();
        rst = r; in_valid = v; op_a = a; op_b = b; sel_odd = odd; is_signed = sgn; half_mode = half;
        if (r) begin
            m_valid = 0; m_res = '0; m_tag = "R8";
        end else if (v) begin
            m_valid = 1; m_res = ref_mul(a, b, odd, sgn, half); m_tag = tag_of(odd, sgn, half);
        end else begin
            m_valid = 0; m_tag = "R7";
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        done = 1;
        rst = 1; in_valid = 0; op_a = '0; op_b = '0; sel_odd = 0; is_signed = 0; half_mode = 0;
        m_valid = 0; m_res = '0; m_tag = "R8";
        @(negedge clk); @(negedge clk);
        done = 0;
        // Reset state (R8)
        step(1, 0, '0, '0, 0, 0, 0);
        // Corner values, all eight modes (R1..R5)
        for (int m = 0; m < 8; m++) begin
            step(0, 1, {16{8'h80}}, {16{8'h80}}, m[0], m[1], m[2]);
            step(0, 1, {8{8'h80, 8'h7F}}, {8{8'h7F, 8'h80}}, m[0], m[1], m[2]);
            step(0, 1, {16{8'hFF}}, {16{8'hFF}}, m[0], m[1], m[2]);
            step(0, 1, {8{16'h8000}}, {8{16'h8000}}, m[0], m[1], m[2]);
            step(0, 1, {4{16'h7FFF, 16'h8000}}, {4{16'h8000, 16'h7FFF}}, m[0], m[1], m[2]);
            step(0, 0, '1, '1, m[0], m[1], m[2]); // R7 hold
        end
        // Aliasing: same operand both sides
        step(0, 1, {4{32'h1234_80FF}}, {4{32'h1234_80FF}}, 1, 1, 0);
        // Random traffic with idle gaps (R6, R7)
        for (int n = 0; n < 600; n++) begin
            logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
            logic [2:0] md = 3'($urandom);
            step(0, ($urandom % 4) != 0, a, b, md[0], md[1], md[2]);
        end
        // Mid-run reset (R8)
        step(0, 1, '1, {16{8'h81}}, 0, 1, 0);
        step(1, 1, '1, '1, 0, 0, 0);
        step(0, 0, '0, '0, 0, 0, 0);
        step(0, 0, '0, '0, 0, 0, 0);
        @(negedge clk);
        check_out();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule